// File: doc/BRIEF.md
# NAND Flash Command Front End

This block models the command side of an 8-bit NAND flash device, clocked by a system clock. Bus cycles are seen through a small edge sampler. A rising edge on the write strobe while the chip is selected latches the byte on the input bus. The byte is taken as a command when the command-latch line is high, or as an address when the address-latch line is high. A falling edge on the read strobe loads the next output byte into a register that drives the output bus.

Two operations are modelled. The identification sequence returns a maker byte and a device byte. The reset command aborts any internal operation, clears the read mode and holds the ready line low for a fixed interval. A status command reports write protection and ready state. A test input starts a stand-in internal operation so that an abort can be exercised. There is no memory array. Outside the identification and status modes, reads return the all-ones content of the data register.

Top module: `nand_cmd_front`

## Requirements
- R1: Commands and addresses are latched only on a write strobe rising edge with `chip_en_n` low. A command needs `cmd_latch` high and `addr_latch` low. An address needs `addr_latch` high and `cmd_latch` low. Strobes with the chip deselected have no effect.
- R2: Command 90h followed by an address cycle of 00h enters identification mode. The first read then returns ECh and the second returns the `DEV_CODE` parameter (default E6h).
- R3: After 90h, an address byte other than 00h leaves identification mode unentered, and reads return FFh.
- R4: Reads past the second identification byte return FFh. Identification mode persists until another accepted command, and a new 90h/00h sequence restarts at ECh.
- R5: A read that begins fewer than `ID_WAIT` clock cycles after the 00h address cycle returns FFh and does not advance the identification sequence.
- R6: A command code other than FFh, 90h or 70h is ignored. It changes neither the read mode, nor the identification position, nor `ready`.
- R7: After command 70h, reads return the status byte. Bit 7 is `wr_protect_n`, bit 6 is `ready`, and bits 5:0 are zero. 70h is accepted while busy or resetting.
- R8: Command FFh drives `ready` low for exactly `RST_CYCLES` clock cycles, counted from the clock edge that samples the strobe rise. It clears the read mode so that reads return FFh. Status read afterwards is C0h when `wr_protect_n` is high and 40h when it is low.
- R9: FFh written during a stand-in internal operation aborts it. `ready` rises `RST_CYCLES` cycles after the reset command, not at the end of the operation.
- R10: FFh written while a reset is in progress is not accepted, and the original release time of `ready` is kept.
- R11: A `tst_busy_start` pulse while ready holds `ready` low for `BUSY_CYCLES` cycles. Command 90h is ignored while `ready` is low.
- R12: After the synchronous reset `rst`, `ready` is high, `bus_out` is FFh and reads return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip select, active low |
| cmd_latch | input | 1 | Marks a write cycle as a command |
| addr_latch | input | 1 | Marks a write cycle as an address |
| wr_strobe_n | input | 1 | Write strobe; the bus is latched on its rising edge |
| rd_strobe_n | input | 1 | Read strobe; its falling edge loads the next output byte |
| wr_protect_n | input | 1 | Write protect, active low; reported in status bit 7 |
| bus_in | input | 8 | Command and address byte |
| tst_busy_start | input | 1 | Test pulse that starts the stand-in internal operation |
| bus_out | output | 8 | Registered read data |
| ready | output | 1 | High when ready, low when busy or resetting |

## Verification
Identification is tried in several ways: a clean sequence, a wrong address byte, a read issued too early, and an unknown command inserted part way through. These separate a correct position counter from one that advances on ignored cycles or restarts on any command. The `ready` low time is measured for four cases: reset from idle, busy without reset, reset during busy, and a second reset during reset. These separate a reset that restarts or fails to abort from a correct one. The status byte is read with write protection at both levels and while busy, so each status bit is shown to follow its own source.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {OP_READY, OP_BUSY, OP_RESET} op_state_t;
  typedef enum logic [1:0] {RM_DATA, RM_ID_ADDR, RM_ID, RM_STATUS} rd_mode_t;

  localparam logic [BUS_W-1:0] CMD_RESET   = 8'hFF;
  localparam logic [BUS_W-1:0] CMD_READ_ID = 8'h90;
  localparam logic [BUS_W-1:0] CMD_STATUS  = 8'h70;
  localparam logic [BUS_W-1:0] ID_ADDR     = 8'h00;
  localparam logic [BUS_W-1:0] MAKER_CODE  = 8'hEC;
  localparam logic [BUS_W-1:0] BLANK       = 8'hFF;
endpackage

// File: rtl/nand_bus_strobe.sv
module nand_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic chip_en_n,
  input  logic cmd_latch,
  input  logic addr_latch,
  input  logic wr_strobe_n,
  input  logic rd_strobe_n,
  output logic cmd_stb,
  output logic addr_stb,
  output logic rd_stb
);
  logic we_q, re_q;
  logic we_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= wr_strobe_n;
      re_q <= rd_strobe_n;
    end
  end

  // R1: latching needs the chip selected and exactly one latch line high
  assign we_rise  = !chip_en_n && wr_strobe_n && !we_q;
  assign cmd_stb  = we_rise && cmd_latch && !addr_latch;
  assign addr_stb = we_rise && addr_latch && !cmd_latch;
  assign rd_stb   = !chip_en_n && !rd_strobe_n && re_q;
endmodule

// File: rtl/nand_op_timer.sv
module nand_op_timer
  import nand_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 40,
  parameter int RST_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_cmd,
  input  logic busy_start,
  output logic ready,
  output logic rst_accept
);
  localparam int MAXC = (BUSY_CYCLES > RST_CYCLES) ? BUSY_CYCLES : RST_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  op_state_t       op_q;
  logic [CW-1:0]   cnt_q;

  // R10: a reset command is refused while a reset is running
  assign rst_accept = rst_cmd && (op_q != OP_RESET);
  assign ready      = (op_q == OP_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_READY;
      cnt_q <= '0;
    end else if (rst_accept) begin
      op_q  <= OP_RESET;
      cnt_q <= CW'(RST_CYCLES - 1);
    end else begin
      case (op_q)
        OP_READY: begin
          if (busy_start) begin
            op_q  <= OP_BUSY;
            cnt_q <= CW'(BUSY_CYCLES - 1);
          end
        end
        default: begin
          if (cnt_q == '0) op_q <= OP_READY;
          else             cnt_q <= cnt_q - CW'(1);
        end
      endcase
    end
  end

  AST_RESET_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    rst_accept |=> !ready); // R8
  AST_RESET_NOT_RESTARTED: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_RESET && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R10
  AST_OP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (op_q != OP_READY && cnt_q == '0 && !rst_accept) |=> ready); // R11
endmodule

// File: rtl/nand_read_path.sv
module nand_read_path
  import nand_cmd_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'hE6,
  parameter int         ID_WAIT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_stb,
  input  logic             addr_stb,
  input  logic             rd_stb,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             ready,
  input  logic             rst_accept,
  input  logic             wr_protect_n,
  output logic [BUS_W-1:0] bus_out
);
  localparam int WW = (ID_WAIT > 0) ? $clog2(ID_WAIT + 1) : 1;

  rd_mode_t         mode_q;
  logic [1:0]       idx_q;
  logic [WW-1:0]    wait_q;
  logic [BUS_W-1:0] out_q;
  logic [BUS_W-1:0] rd_byte;

  always_comb begin
    case (mode_q)
      RM_ID: begin
        if (wait_q != '0) rd_byte = BLANK;
        else begin
          case (idx_q)
            2'd0:    rd_byte = MAKER_CODE;
            2'd1:    rd_byte = DEV_CODE;
            default: rd_byte = BLANK;
          endcase
        end
      end
      RM_STATUS: rd_byte = {wr_protect_n, ready, 6'b0};
      default:   rd_byte = BLANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RM_DATA;
      idx_q  <= 2'd0;
      wait_q <= '0;
      out_q  <= BLANK;
    end else begin
      if (wait_q != '0) wait_q <= wait_q - WW'(1);
      if (rd_stb) begin
        out_q <= rd_byte;
        if (mode_q == RM_ID && wait_q == '0 && idx_q != 2'd2) idx_q <= idx_q + 2'd1;
      end
      if (rst_accept) begin
        mode_q <= RM_DATA;
      end else if (cmd_stb) begin
        if (bus_in == CMD_STATUS) mode_q <= RM_STATUS;
        else if (bus_in == CMD_READ_ID && ready) mode_q <= RM_ID_ADDR;
      end else if (addr_stb && mode_q == RM_ID_ADDR) begin
        if (bus_in == ID_ADDR) begin
          mode_q <= RM_ID;
          idx_q  <= 2'd0;
          wait_q <= WW'(ID_WAIT);
        end else begin
          mode_q <= RM_DATA;
        end
      end
    end
  end

  assign bus_out = out_q;

  AST_ID_FIRST_BYTE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !addr_stb && mode_q == RM_ID && wait_q == '0 && idx_q == 2'd0)
      |=> (bus_out == MAKER_CODE)); // R2
  AST_EARLY_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !addr_stb && !cmd_stb && mode_q == RM_ID && wait_q != '0)
      |=> (bus_out == BLANK && idx_q == $past(idx_q))); // R5
  AST_ID_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= 2'd2); // R4
  AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && mode_q == RM_STATUS) |=> (bus_out[5:0] == 6'd0)); // R7
  AST_RESET_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
    rst_accept |=> (mode_q == RM_DATA)); // R8
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_cmd_pkg::*;
#(
  parameter logic [7:0] DEV_CODE    = 8'hE6,
  parameter int         ID_WAIT     = 4,
  parameter int         BUSY_CYCLES = 40,
  parameter int         RST_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chip_en_n,
  input  logic       cmd_latch,
  input  logic       addr_latch,
  input  logic       wr_strobe_n,
  input  logic       rd_strobe_n,
  input  logic       wr_protect_n,
  input  logic [7:0] bus_in,
  input  logic       tst_busy_start,
  output logic [7:0] bus_out,
  output logic       ready
);
  logic cmd_stb, addr_stb, rd_stb;
  logic rst_accept;
  logic rst_cmd;

  nand_bus_strobe u_strobe (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
    .cmd_stb(cmd_stb), .addr_stb(addr_stb), .rd_stb(rd_stb)
  );

  assign rst_cmd = cmd_stb && (bus_in == CMD_RESET);

  nand_op_timer #(.BUSY_CYCLES(BUSY_CYCLES), .RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .rst_cmd(rst_cmd), .busy_start(tst_busy_start),
    .ready(ready), .rst_accept(rst_accept)
  );

  nand_read_path #(.DEV_CODE(DEV_CODE), .ID_WAIT(ID_WAIT)) u_read (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb), .rd_stb(rd_stb),
    .bus_in(bus_in), .ready(ready), .rst_accept(rst_accept),
    .wr_protect_n(wr_protect_n), .bus_out(bus_out)
  );
endmodule

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
  localparam logic [7:0] DEV  = 8'hE6;
  localparam int         IDW  = 4;
  localparam int         BUSY = 40;
  localparam int         RSTC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en_n = 1'b1, cmd_latch = 1'b0, addr_latch = 1'b0;
  logic wr_strobe_n = 1'b1, rd_strobe_n = 1'b1, wr_protect_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic tst_busy_start = 1'b0;
  logic [7:0] bus_out;
  logic ready;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nand_cmd_front #(.DEV_CODE(DEV), .ID_WAIT(IDW), .BUSY_CYCLES(BUSY), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
    .wr_protect_n(wr_protect_n), .bus_in(bus_in), .tst_busy_start(tst_busy_start),
    .bus_out(bus_out), .ready(ready)
  );

  task automatic check(input string tag, input int got, input int expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic write_cyc(input logic is_cmd, input logic [7:0] b);
    cmd_latch = is_cmd; addr_latch = !is_cmd; bus_in = b; wr_strobe_n = 1'b0;
    @(negedge clk) wr_strobe_n = 1'b1;
    @(negedge clk) begin cmd_latch = 1'b0; addr_latch = 1'b0; end
  endtask

  task automatic read_cyc(output logic [7:0] v);
    rd_strobe_n = 1'b0;
    @(negedge clk) v = bus_out;
    rd_strobe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic enter_id();
    write_cyc(1'b1, 8'h90);
    write_cyc(1'b0, 8'h00);
    repeat (IDW + 1) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    check("R12 ready", int'(ready), 1);
    check("R12 bus_out", int'(bus_out), 8'hFF);
    read_cyc(v); check("R12 read", int'(v), 8'hFF);
  endtask

  task automatic t_read_id();
    logic [7:0] v;
    enter_id();
    read_cyc(v); check("R2 maker", int'(v), 8'hEC);
    read_cyc(v); check("R2 device", int'(v), int'(DEV));
    read_cyc(v); check("R4 third", int'(v), 8'hFF);
    read_cyc(v); check("R4 fourth", int'(v), 8'hFF);
    enter_id();
    read_cyc(v); check("R4 restart", int'(v), 8'hEC);
  endtask

  task automatic t_bad_addr();
    logic [7:0] v;
    write_cyc(1'b1, 8'h90);
    write_cyc(1'b0, 8'h01);
    repeat (IDW + 1) @(negedge clk);
    read_cyc(v); check("R3 bad addr", int'(v), 8'hFF);
  endtask

  task automatic t_early();
    logic [7:0] v;
    write_cyc(1'b1, 8'h90);
    write_cyc(1'b0, 8'h00);
    read_cyc(v); check("R5 early", int'(v), 8'hFF);
    repeat (IDW + 1) @(negedge clk);
    read_cyc(v); check("R5 after wait", int'(v), 8'hEC);
  endtask

  task automatic t_unknown();
    logic [7:0] v;
    enter_id();
    read_cyc(v); check("R6 maker", int'(v), 8'hEC);
    write_cyc(1'b1, 8'h55);
    check("R6 ready", int'(ready), 1);
    read_cyc(v); check("R6 position kept", int'(v), int'(DEV));
  endtask

  task automatic t_deselect();
    logic [7:0] v;
    write_cyc(1'b1, 8'h70);
    chip_en_n = 1'b1;
    write_cyc(1'b1, 8'h90);
    write_cyc(1'b0, 8'h00);
    write_cyc(1'b1, 8'hFF);
    check("R1 deselected reset", int'(ready), 1);
    chip_en_n = 1'b0;
    repeat (IDW + 1) @(negedge clk);
    read_cyc(v); check("R1 still status", int'(v), 8'hC0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    int n;
    write_cyc(1'b1, 8'h70);
    read_cyc(v); check("R7 wp high", int'(v), 8'hC0);
    wr_protect_n = 1'b0;
    read_cyc(v); check("R7 wp low", int'(v), 8'h40);
    wr_protect_n = 1'b1;
    tst_busy_start = 1'b1;
    @(negedge clk) tst_busy_start = 1'b0;
    write_cyc(1'b1, 8'h70);
    read_cyc(v); check("R7 busy", int'(v), 8'h80);
    count_low(n);
  endtask

  task automatic t_reset_cmd();
    logic [7:0] v;
    int n;
    enter_id();
    write_cyc(1'b1, 8'hFF);
    count_low(n); check("R8 low time", n, RSTC);
    read_cyc(v); check("R8 mode cleared", int'(v), 8'hFF);
    write_cyc(1'b1, 8'h70);
    read_cyc(v); check("R8 status C0", int'(v), 8'hC0);
    wr_protect_n = 1'b0;
    read_cyc(v); check("R8 status wp low", int'(v), 8'h40);
    wr_protect_n = 1'b1;
  endtask

  task automatic t_busy();
    logic [7:0] v;
    int n;
    write_cyc(1'b1, 8'hFF);
    count_low(n);
    tst_busy_start = 1'b1;
    @(negedge clk) tst_busy_start = 1'b0;
    count_low(n); check("R11 busy time", n, BUSY);
    tst_busy_start = 1'b1;
    @(negedge clk) tst_busy_start = 1'b0;
    write_cyc(1'b1, 8'h90);
    write_cyc(1'b0, 8'h00);
    count_low(n);
    repeat (IDW + 1) @(negedge clk);
    read_cyc(v); check("R11 id ignored when busy", int'(v), 8'hFF);
  endtask

  task automatic t_abort();
    int n;
    tst_busy_start = 1'b1;
    @(negedge clk) tst_busy_start = 1'b0;
    repeat (5) @(negedge clk);
    write_cyc(1'b1, 8'hFF);
    count_low(n); check("R9 abort time", n, RSTC);
  endtask

  task automatic t_rereset();
    int n;
    write_cyc(1'b1, 8'hFF);
    write_cyc(1'b1, 8'hFF);
    count_low(n); check("R10 second reset refused", n, RSTC - 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chip_en_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_read_id();
    t_bad_addr();
    t_early();
    t_unknown();
    t_deselect();
    t_status();
    t_reset_cmd();
    t_busy();
    t_abort();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule